// File: doc/BRIEF.md
# Microcode Store Address Sequencer

This block holds the loading registers for a writeable microcode store. A 16-bit address register carries a 13-bit word address in its low bits, a 2-bit sub-word counter above it, and one spare bit on top. Software first loads the address register. It then writes the data register once for each slice of a microword. Every data write moves the sub-word counter forward by one. When that step brings the counter to its terminal value of 3, the word address also advances by one. A long run of data writes therefore fills consecutive microwords with no further address loads.

A separate 13-bit microbreak register stores the microaddress at which a break is wanted. The data register cannot be read back: a read of it returns a fixed pattern. Its latched value, the current word address and the counter leave the block on dedicated outputs, which feed the store itself. The store is not part of this block.

All registers sit behind one select field, with a write strobe and a read strobe and 32-bit data in each direction. Writes take effect at the clock edge on which the strobe is sampled. Reads are combinational from the current register state.

Top module: `wcs_addr_sequencer`

## Requirements
- R1: After reset the address register, the data register and the microbreak register are all zero, so every state output is zero and a read of the address register returns 0.
- R2: A write with select 0 (address register) stores bits 15:0 of the write data. From the next clock the register reads back as those 16 bits in bits 15:0, with bits 31:16 zero. Bits 12:0 are the word address and bits 14:13 are the sub-word counter.
- R3: A write with select 1 (data register) latches all 32 data bits onto the data output and adds 1 to the counter modulo 4. Both updates appear in the clock after the strobe.
- R4: On a data write whose incremented counter equals 3, the word address increases by 1 modulo 8192 on the same clock edge. On any other data write the word address is unchanged.
- R5: A read with select 1 always returns 0x000000FF, whatever was last written.
- R6: A write with select 2 (microbreak) stores bits 12:0. It reads back zero-extended, and the higher write bits are dropped.
- R7: Bit 15 of the address register is stored and read back. It has no effect on the counter or the address step, and data writes leave it unchanged.
- R8: Select 3 selects nothing. A write to it changes no register, and a read of it returns 0. When the read strobe is low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 microbreak, 3 none |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data (combinational) |
| cs_word_addr | output | 13 | Current microword address |
| cs_phase | output | 2 | Current sub-word counter |
| cs_wdata | output | 32 | Last value written to the data register |
| brk_addr | output | 13 | Microbreak address |

## Verification
The hardest case to reach is the carry out of the top word address, 0x1FFF, back to zero. It coincides with the counter reaching 3, and it must happen with bit 15 both clear and set. Reaching it by data writes alone would take tens of thousands of writes. The stimulus therefore preloads the address register with the counter at 2 and the word address at its maximum, then issues one data write. A later run of many back-to-back data writes then checks the full four-step counter pattern against a behavioural model on every clock.

// File: rtl/wcs_pkg.sv
`timescale 1ns/1ps
package wcs_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_BRK  = 2'd2,
      SEL_NONE = 2'd3
   } wcs_sel_e;

   localparam int unsigned WCS_DATA_W = 32;
   localparam int unsigned WCS_ADDR_W = 13;
   localparam int unsigned WCS_CNT_W  = 2;
   localparam int unsigned WCS_REG_W  = 16;
   localparam int unsigned WCS_BRK_W  = 13;
endpackage

// File: rtl/wcs_hold_reg.sv
`timescale 1ns/1ps
module wcs_hold_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      initial $fatal(1, "wcs_hold_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/wcs_addr_seq.sv
`timescale 1ns/1ps
module wcs_addr_seq #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned CNT_W  = 2,
   parameter int unsigned REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [REG_W-1:0]  load_val,
   input  logic              step_en,
   output logic [ADDR_W-1:0] q_addr,
   output logic [CNT_W-1:0]  q_cnt,
   output logic [REG_W-1:0]  q_reg
);
   localparam int unsigned FIELD_W = ADDR_W + CNT_W;
   localparam int unsigned SPARE_W = REG_W - FIELD_W;
   localparam logic [CNT_W-1:0] CNT_TERM   = '1;
   localparam logic [CNT_W-1:0] CNT_PRETERM = CNT_TERM - 1'b1;

   if (REG_W < FIELD_W) begin : g_bad_reg
      initial $fatal(1, "wcs_addr_seq: REG_W too small for fields");
   end
   if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_fields
      initial $fatal(1, "wcs_addr_seq: field widths must be positive");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              carry;

   always_comb begin
      cnt_nxt = cnt_q + 1'b1;
      carry   = (cnt_nxt == CNT_TERM);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (load_en) begin
         addr_q <= load_val[ADDR_W-1:0];
         cnt_q  <= load_val[FIELD_W-1:ADDR_W];
      end else if (step_en) begin
         cnt_q <= cnt_nxt;
         if (carry) addr_q <= addr_q + 1'b1;
      end
   end

   assign q_addr = addr_q;
   assign q_cnt  = cnt_q;

   if (SPARE_W > 0) begin : g_spare
      logic [SPARE_W-1:0] spare_q;
      always_ff @(posedge clk) begin
         if (!rst_n)       spare_q <= '0;
         else if (load_en) spare_q <= load_val[REG_W-1:FIELD_W];
      end
      assign q_reg = {spare_q, cnt_q, addr_q};

      // R7: data steps never disturb the spare bits
      a_r7_spare_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (step_en && !load_en) |=> $stable(spare_q));
   end else begin : g_nospare
      assign q_reg = {cnt_q, addr_q};
   end

   // R3: each step advances the counter by one modulo its range
   a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R4: reaching the terminal count advances the word address
   a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en && cnt_q == CNT_PRETERM)
         |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

   // R4: other steps leave the word address alone
   a_r4_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en && cnt_q != CNT_PRETERM) |=> $stable(addr_q));

   // R8: without a load or step the fields hold
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !load_en) |=> ($stable(addr_q) && $stable(cnt_q)));
endmodule

// File: rtl/wcs_addr_sequencer.sv
`timescale 1ns/1ps
module wcs_addr_sequencer
   import wcs_pkg::*;
#(
   parameter int unsigned DATA_W  = WCS_DATA_W,
   parameter int unsigned ADDR_W  = WCS_ADDR_W,
   parameter int unsigned CNT_W   = WCS_CNT_W,
   parameter int unsigned REG_W   = WCS_REG_W,
   parameter int unsigned BRK_W   = WCS_BRK_W,
   parameter logic [7:0]  RD_CONST = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] cs_word_addr,
   output logic [CNT_W-1:0]  cs_phase,
   output logic [DATA_W-1:0] cs_wdata,
   output logic [BRK_W-1:0]  brk_addr
);
   if (DATA_W < REG_W || DATA_W < BRK_W || DATA_W < 8) begin : g_bad_data
      initial $fatal(1, "wcs_addr_sequencer: DATA_W too narrow");
   end

   wcs_sel_e sel;
   assign sel = wcs_sel_e'(reg_sel);

   logic wr_addr, wr_dat, wr_brk;
   always_comb begin
      wr_addr = wr_en && (sel == SEL_ADDR);
      wr_dat  = wr_en && (sel == SEL_DATA);
      wr_brk  = wr_en && (sel == SEL_BRK);
   end

   logic [REG_W-1:0] addr_reg;

   wcs_addr_seq #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .REG_W  (REG_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (wr_addr),
      .load_val (wr_data[REG_W-1:0]),
      .step_en  (wr_dat),
      .q_addr   (cs_word_addr),
      .q_cnt    (cs_phase),
      .q_reg    (addr_reg)
   );

   wcs_hold_reg #(.W(DATA_W)) u_data (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (wr_dat),
      .d     (wr_data),
      .q     (cs_wdata)
   );

   wcs_hold_reg #(.W(BRK_W)) u_brk (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (wr_brk),
      .d     (wr_data[BRK_W-1:0]),
      .q     (brk_addr)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         unique case (sel)
            SEL_ADDR: rd_data = DATA_W'(addr_reg);
            SEL_DATA: rd_data = DATA_W'(RD_CONST);
            SEL_BRK:  rd_data = DATA_W'(brk_addr);
            default:  rd_data = '0;
         endcase
      end
   end

   // R5: data register reads never reflect written data
   a_r5_data_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_sel == 2'd1 && $past(wr_dat)) |-> (rd_data != cs_wdata || cs_wdata == DATA_W'(RD_CONST)));

   // R6: break register changes only on its own write
   a_r6_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_brk |=> $stable(brk_addr));
endmodule

// File: tb/wcs_addr_sequencer_test.sv
`timescale 1ns/1ps
module wcs_addr_sequencer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en;
   logic [1:0]  reg_sel;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic [12:0] cs_word_addr;
   logic [1:0]  cs_phase;
   logic [31:0] cs_wdata;
   logic [12:0] brk_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] m_addr;
   logic [31:0] m_data;
   logic [12:0] m_brk;

   always #2 clk = ~clk;

   wcs_addr_sequencer uut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
      .reg_sel (reg_sel), .wr_data (wr_data), .rd_data (rd_data),
      .cs_word_addr (cs_word_addr), .cs_phase (cs_phase),
      .cs_wdata (cs_wdata), .brk_addr (brk_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [1:0] s);
      case (s)
         2'd0:    return {16'h0, m_addr};
         2'd1:    return 32'h0000_00FF;
         2'd2:    return {19'h0, m_brk};
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_write(input logic [1:0] s, input logic [31:0] d);
      int c, w;
      case (s)
         2'd0: m_addr = d[15:0];
         2'd1: begin
            m_data = d;
            c = (int'(m_addr) >> 13) & 3;
            w = int'(m_addr) & 8191;
            c = (c + 1) % 4;
            if (c == 3) w = (w + 1) % 8192;
            m_addr = (m_addr & 16'h8000) | 16'(c << 13) | 16'(w);
         end
         2'd2: m_brk = d[12:0];
         default: ;
      endcase
   endtask

   task automatic cmp_state(input string req);
      chk({req, " word_addr"}, {19'h0, cs_word_addr}, {19'h0, m_addr[12:0]});
      chk({req, " phase"},     {30'h0, cs_phase},     {30'h0, m_addr[14:13]});
      chk({req, " wdata"},     cs_wdata,              m_data);
      chk({req, " brk"},       {19'h0, brk_addr},     {19'h0, m_brk});
   endtask

   // called at a negedge; leaves at the next negedge
   task automatic op(input string req, input bit w, input bit r,
                     input logic [1:0] s, input logic [31:0] d);
      wr_en = w; rd_en = r; reg_sel = s; wr_data = d;
      #1;
      chk({req, " rd_data"}, rd_data, r ? model_read(s) : 32'h0);
      @(posedge clk);
      if (w) model_write(s, d);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      cmp_state(req);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; reg_sel = 2'd0; wr_data = '0;
      m_addr = '0; m_data = '0; m_brk = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cmp_state("R1 reset");
      op("R1 addr read", 1'b0, 1'b1, 2'd0, 32'h0);

      op("R2 addr load", 1'b1, 1'b0, 2'd0, 32'hABCD_1234);
      op("R2 addr readback", 1'b0, 1'b1, 2'd0, 32'h0);
      op("R3 data write", 1'b1, 1'b0, 2'd1, 32'hDEAD_BEEF);
      op("R5 data read", 1'b0, 1'b1, 2'd1, 32'h0);
      op("R3 data write 2", 1'b1, 1'b1, 2'd1, 32'h1234_5678);

      // load counter 0, addr 0x0010 and step through several groups
      op("R2 addr load 2", 1'b1, 1'b0, 2'd0, 32'h0000_0010);
      for (int i = 0; i < 40; i++)
         op("R4 step run", 1'b1, 1'b0, 2'd1, 32'h1000_0000 + i);
      op("R4 run readback", 1'b0, 1'b1, 2'd0, 32'h0);

      // top-of-range wrap, bit 15 clear
      op("R4 preload max", 1'b1, 1'b0, 2'd0, 32'h0000_5FFF);
      op("R4 wrap", 1'b1, 1'b0, 2'd1, 32'h0000_0001);
      op("R4 wrap read", 1'b0, 1'b1, 2'd0, 32'h0);
      // top-of-range wrap, bit 15 set
      op("R7 preload max", 1'b1, 1'b0, 2'd0, 32'h0000_DFFF);
      op("R7 wrap", 1'b1, 1'b0, 2'd1, 32'h0000_0002);
      op("R7 wrap read", 1'b0, 1'b1, 2'd0, 32'h0);
      for (int i = 0; i < 6; i++)
         op("R7 bit15 run", 1'b1, 1'b0, 2'd1, 32'h2000_0000 + i);
      op("R7 run read", 1'b0, 1'b1, 2'd0, 32'h0);

      op("R6 brk write", 1'b1, 1'b0, 2'd2, 32'hFFFF_F5A5);
      op("R6 brk read", 1'b0, 1'b1, 2'd2, 32'h0);
      op("R6 brk write 2", 1'b1, 1'b1, 2'd2, 32'h0000_0123);

      op("R8 null write", 1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF);
      op("R8 null read", 1'b0, 1'b1, 2'd3, 32'h0);
      op("R8 rd_en low", 1'b0, 1'b0, 2'd0, 32'h0);
      op("R5 data read 2", 1'b0, 1'b1, 2'd1, 32'h0);

      // reset mid-run
      op("R2 addr load 3", 1'b1, 1'b0, 2'd0, 32'h0000_7777);
      rst_n = 1'b0;
      @(posedge clk);
      m_addr = '0; m_data = '0; m_brk = '0;
      @(negedge clk);
      rst_n = 1'b1;
      cmp_state("R1 reset 2");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule